// File: doc/BRIEF.md
# Masked channel change event detector

This block compares a 32-channel state vector, taken on a sample strobe, with the states it kept from the previous sample. Every channel that differs and is enabled yields one event. An event carries the channel number and whether the channel went high or low. The events of one sample wait in a pending vector and leave one per handshake on a valid/ready port. The lowest channel number always leaves first.

Each channel has its own enable bit. The whole enable mask is written in one cycle. When a channel goes from disabled to enabled, its stored previous state is replaced with its live input. A condition that built up while the channel was disabled therefore raises no event. A strobe that arrives while events are still draining waits in a one-deep slot. The block shows this on its busy output and handles that sample once the pending vector is empty.

Top module: `chan_evt_det`

## Requirements
- R1: After reset the block presents no event and busy_o is low. All channels are enabled and every stored previous state is 0.
- R2: A processed sample marks as changed each channel whose new bit differs from its stored previous bit. A sample with no changed channel yields no event.
- R3: An event is produced only for a channel that is both changed and enabled in the mask at the moment the sample is processed.
- R4: evt_rise_o is 1 when the channel's new bit is 1 (rising) and 0 when it is 0 (falling).
- R5: Once a sample is processed, every stored previous state takes the sample's value, masked channels included.
- R6: When mask_we_i sets a mask bit that was 0, that channel's stored previous state is loaded from chan_i in the same cycle. Clearing a mask bit changes nothing else.
- R7: The events of one sample leave in strictly ascending channel order on evt_idx_o, a 5-bit binary channel number. One event is removed per cycle in which evt_valid_o and evt_ready_i are both high.
- R8: While evt_valid_o is high and evt_ready_i is low, evt_valid_o, evt_idx_o and evt_rise_o keep their values into the next cycle.
- R9: A strobe is taken at once only when no event is pending and the slot is empty. Otherwise chan_i is stored in the one-deep slot, and a later strobe overwrites the stored value. The stored sample is processed in the first cycle with no event pending. busy_o is high while an event is pending or the slot is full.
- R10: When a mask write and sample processing fall in the same cycle, processing uses the mask as it was before the write. A newly enabled channel's previous state still takes its chan_i bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Sample strobe for chan_i |
| chan_i | input | 32 | Live channel states |
| mask_we_i | input | 1 | Write strobe for the enable mask |
| mask_i | input | 32 | New enable mask, 1 = enabled |
| evt_valid_o | output | 1 | An event is presented |
| evt_ready_i | input | 1 | Consumer takes the event |
| evt_idx_o | output | 5 | Channel number of the event |
| evt_rise_o | output | 1 | 1 = rising, 0 = falling |
| busy_o | output | 1 | Events pending or a strobe is waiting |

## Verification
The directed patterns each isolate one rule:
- A first sample from the all-zero reset state shows rising events in ascending order.
- A repeated identical sample must produce nothing.
- A sample that toggles both masked and unmasked channels shows that the mask filters events and that falling events are tagged.
- A channel disabled, toggled, moved back and re-enabled proves the re-seed, since without it a falling event would appear.

Strobes issued during a stalled drain exercise the hold slot and its overwrite. A long random phase then mixes strobes, mask writes and ready stalls, and a cycle-level queue model is compared against the port outputs every cycle.

// File: rtl/chan_evt_pkg.sv
package chan_evt_pkg;
  typedef enum logic {
    EVT_FALL = 1'b0,
    EVT_RISE = 1'b1
  } evt_dir_e;
endpackage

// File: rtl/evt_prio_enc.sv
module evt_prio_enc #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/evt_baseline.sv
module evt_baseline #(
  parameter int NCH = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sample_i,
  input  logic [NCH-1:0] chan_i,
  input  logic           mask_we_i,
  input  logic [NCH-1:0] mask_i,
  input  logic           idle_i,
  output logic           load_o,
  output logic [NCH-1:0] load_set_o,
  output logic [NCH-1:0] load_val_o,
  output logic           hold_v_o
);
  logic [NCH-1:0] mask_q, prev_q, hold_q, src, en_rise;
  logic           hold_v_q, proc_new, proc_hold;

  assign proc_new   = sample_i & idle_i & ~hold_v_q;
  assign proc_hold  = idle_i & hold_v_q;
  assign src        = proc_hold ? hold_q : chan_i;
  assign load_o     = proc_new | proc_hold;
  assign load_set_o = (prev_q ^ src) & mask_q;
  assign load_val_o = src;
  assign hold_v_o   = hold_v_q;
  assign en_rise    = mask_we_i ? (mask_i & ~mask_q) : '0;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q[g] <= 1'b1;
        prev_q[g] <= 1'b0;
      end else begin
        if (en_rise[g])  prev_q[g] <= chan_i[g];  // re-seed wins
        else if (load_o) prev_q[g] <= src[g];
        if (mask_we_i)   mask_q[g] <= mask_i[g];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q <= 1'b0;
      hold_q   <= '0;
    end else if (proc_hold) begin
      hold_v_q <= sample_i;
      if (sample_i) hold_q <= chan_i;
    end else if (sample_i && !proc_new) begin
      hold_v_q <= 1'b1;
      hold_q   <= chan_i;
    end
  end
endmodule

// File: rtl/chan_evt_det.sv
module chan_evt_det
  import chan_evt_pkg::*;
#(
  parameter int NCH  = 32,
  parameter int IDXW = $clog2(NCH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sample_i,
  input  logic [NCH-1:0]  chan_i,
  input  logic            mask_we_i,
  input  logic [NCH-1:0]  mask_i,
  output logic            evt_valid_o,
  input  logic            evt_ready_i,
  output logic [IDXW-1:0] evt_idx_o,
  output logic            evt_rise_o,
  output logic            busy_o
);
  logic [NCH-1:0]  pend_q, samp_q, load_set, load_val;
  logic            load, hold_v, fire;
  logic [IDXW-1:0] idx;
  evt_dir_e        dir;

  evt_baseline #(.NCH(NCH)) u_base (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_i   (sample_i),
    .chan_i     (chan_i),
    .mask_we_i  (mask_we_i),
    .mask_i     (mask_i),
    .idle_i     (~|pend_q),
    .load_o     (load),
    .load_set_o (load_set),
    .load_val_o (load_val),
    .hold_v_o   (hold_v)
  );

  evt_prio_enc #(.W(NCH), .IW(IDXW)) u_enc (
    .vec_i (pend_q),
    .idx_o (idx)
  );

  assign fire = evt_valid_o & evt_ready_i;

  // load only happens with pend_q empty, so it never meets a fire
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      samp_q <= '0;
    end else if (load) begin
      pend_q <= load_set;
      samp_q <= load_val;
    end else if (fire) begin
      pend_q[idx] <= 1'b0;
    end
  end

  assign dir         = evt_dir_e'(samp_q[idx]);
  assign evt_valid_o = |pend_q;
  assign evt_idx_o   = idx;
  assign evt_rise_o  = (dir == EVT_RISE);
  assign busy_o      = evt_valid_o | hold_v;
endmodule

// File: rtl/chan_evt_det_chk.sv
module chan_evt_det_chk #(
  parameter int IDXW = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sample_i,
  input logic            evt_valid_o,
  input logic            evt_ready_i,
  input logic [IDXW-1:0] evt_idx_o,
  input logic            evt_rise_o,
  input logic            busy_o
);
  a_r8_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o && !evt_ready_i |=> evt_valid_o && $stable(evt_idx_o) && $stable(evt_rise_o));

  a_r7_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o && evt_ready_i |=> !evt_valid_o || (evt_idx_o > $past(evt_idx_o)));

  a_r9_valid_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> busy_o);

  a_r9_strobe_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i && busy_o |=> busy_o);
endmodule

bind chan_evt_det chan_evt_det_chk #(.IDXW(IDXW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sample_i    (sample_i),
  .evt_valid_o (evt_valid_o),
  .evt_ready_i (evt_ready_i),
  .evt_idx_o   (evt_idx_o),
  .evt_rise_o  (evt_rise_o),
  .busy_o      (busy_o)
);

// File: tb/sim_chan_evt_det.sv
`timescale 1ns/1ps
module sim_chan_evt_det;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample = 1'b0;
  logic [31:0] chan = '0;
  logic        mask_we = 1'b0;
  logic [31:0] mask_in = '0;
  logic        ready = 1'b1;
  logic        valid, rise, busy;
  logic [4:0]  idx;

  int    errors = 0, checks = 0, n_fire = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #4 clk = ~clk;

  chan_evt_det u0 (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .chan_i(chan),
    .mask_we_i(mask_we), .mask_i(mask_in), .evt_valid_o(valid),
    .evt_ready_i(ready), .evt_idx_o(idx), .evt_rise_o(rise), .busy_o(busy)
  );

  // behavioural reference
  logic [31:0] m_mask, m_prev, m_hold;
  bit          m_hv;
  int          q_idx[$];
  bit          q_dir[$];

  task automatic m_proc(input logic [31:0] v);
    for (int i = 0; i < 32; i++)
      if ((m_prev[i] != v[i]) && m_mask[i]) begin
        q_idx.push_back(i);
        q_dir.push_back(v[i]);
      end
    m_prev = v;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = '1; m_prev = '0; m_hold = '0; m_hv = 0;
      q_idx.delete(); q_dir.delete();
    end else begin
      bit empty0, hv0;
      empty0 = (q_idx.size() == 0);
      hv0    = m_hv;
      if (!empty0 && ready) begin
        void'(q_idx.pop_front()); void'(q_dir.pop_front());
        n_fire++;
      end
      if (empty0 && !hv0 && sample) m_proc(chan);
      else if (empty0 && hv0) begin
        m_proc(m_hold);
        m_hv = sample;
        if (sample) m_hold = chan;
      end else if (sample) begin
        m_hv = 1; m_hold = chan;
      end
      if (mask_we) begin
        for (int i = 0; i < 32; i++)
          if (mask_in[i] && !m_mask[i]) m_prev[i] = chan[i];
        m_mask = mask_in;
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ev;
      ev = (q_idx.size() != 0);
      chk("valid", valid, ev);
      chk("busy", busy, ev || m_hv);
      if (ev && valid) begin
        chk("idx", idx, q_idx[0]);
        chk("dir", rise, q_dir[0]);
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic strobe(input logic [31:0] v);
    chan = v; sample = 1; tick(); sample = 0;
  endtask
  task automatic wmask(input logic [31:0] m);
    mask_in = m; mask_we = 1; tick(); mask_we = 0;
  endtask
  task automatic drain();
    for (int k = 0; k < 200 && (busy || valid); k++) tick();
    tick();
  endtask

  initial begin
    int base;
    repeat (3) tick();
    // R1: reset state
    chk("reset valid", valid, 0);
    chk("reset busy", busy, 0);
    rst_n = 1; tick();
    // R2 R4 R7: first sample from zero baseline, rising ascending
    cur_req = "R2"; base = n_fire;
    strobe(32'h0000_00A5); drain();
    chk("event count", n_fire - base, 4);
    // R5: identical sample yields nothing
    cur_req = "R5"; base = n_fire;
    strobe(32'h0000_00A5); drain();
    chk("event count", n_fire - base, 0);
    // R3 R4: masked channels filtered, falling tagged
    cur_req = "R3"; wmask(32'hFFFF_FFF0); base = n_fire;
    strobe(32'h0000_0000); drain();
    chk("event count", n_fire - base, 2);
    // R6: disable ch7, toggle, move back, re-enable -> no event
    cur_req = "R6"; wmask(32'hFFFF_FF70);
    strobe(32'h0000_0080); drain();
    chan = 32'h0; tick();
    wmask(32'hFFFF_FFF0); base = n_fire;
    strobe(32'h0000_0000); drain();
    chk("event count", n_fire - base, 0);
    // R8 R9: stall and strobes while busy
    cur_req = "R8"; ready = 0;
    strobe(32'hF000_000F);
    repeat (3) tick();
    cur_req = "R9";
    strobe(32'h0F00_0000);
    strobe(32'h00F0_0000);
    repeat (3) tick();
    ready = 1; drain();
    // R10: mask write in the cycle that processes a sample
    cur_req = "R10";
    chan = 32'h0000_FFFF; mask_in = 32'hFFFF_0000; sample = 1; mask_we = 1;
    tick(); sample = 0; mask_we = 0; drain();
    wmask(32'hFFFF_FFFF);
    // R7: random mix
    cur_req = "R7";
    for (int n = 0; n < 4000; n++) begin
      ready   = ($urandom_range(3) != 0);
      sample  = ($urandom_range(3) == 0);
      chan    = chan ^ ($urandom() & $urandom());
      mask_we = ($urandom_range(15) == 0);
      mask_in = $urandom() | $urandom();
      tick();
    end
    sample = 0; mask_we = 0; ready = 1; drain();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule